// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function legacy I/O chip. A host reaches it through a two-byte window: one byte is an index port and the other is a data port. The host decodes the window (0x398 by default) and drives a one-bit port select. The index port selects one of three 8-bit configuration registers: function enable, function address and power/test. The data port reads and writes the selected register. Right after reset, the first index-port reads return a chip identifier. This lets software probe for the device before it configures anything.

A 5-bit strap sampled during reset sets the starting register contents. The block continuously decodes the current contents into a base address and an IRQ number for the parallel port, two serial ports, the floppy controller and the IDE controller. These decoded settings are registered. An accepted data write raises a single-cycle reconfigure pulse, so that the function blocks downstream can re-latch their settings.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index-port read returns the selected index.
- R2: An index-port write stores the written byte as the selected index and ends the identifier sequence. The next index-port read returns that byte.
- R3: A data-port write with selected index 0 (enable), 1 (address) or 2 (power/test) updates that register. A data-port read returns it in the same cycle the read is presented.
- R4: A data-port write with a selected index of 3 or more changes no register, decoded output or pulse. A data-port read at such an index returns 0x00.
- R5: During reset the registers load from the strap. Examples: strap 0 gives enable 0x4F and address 0x10; strap 13 gives enable 0x0F and address 0x11; strap 31 gives enable 0x00, address 0x10 and power/test 0x02. Power/test is 0x00 for every other strap. The selected index resets to 0.
- R6: The enable register drives the enables: bit 0 parallel, bit 1 first serial port, bit 2 second serial port, bit 3 floppy, bit 6 IDE.
- R7: The floppy base is 0x370 when enable bit 5 is set and 0x3F0 when it is clear. The floppy IRQ is 6.
- R8: The IDE base is 0x170 when enable bit 7 is set and 0x1F0 when it is clear. The IDE alternate base is the IDE base plus 0x206. The IDE IRQ is 14.
- R9: Address bits [1:0] select the parallel base: 0 gives 0x378, 1 gives 0x3BC, 2 gives 0x278, 3 gives none (0). The parallel IRQ is 7 for code 1, 5 for code 2 and 0 for code 3. For code 0 it is 7 when power/test bit 3 is set and 5 when it is clear.
- R10: The first serial port uses address bits [3:2] as its code and the second uses bits [5:4]. Code 0 gives 0x3F8 and code 1 gives 0x2F8. Code 2 gives 0x3E8, 0x338, 0x2E8 or 0x220, and code 3 gives 0x2E8, 0x238, 0x2E0 or 0x228, in both cases for address bits [7:6] = 0, 1, 2, 3.
- R11: A serial port's IRQ is 3 when its code is odd and 4 when it is even.
- R12: Decoded outputs reflect a data write one clock after the write edge. The reconfigure pulse is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads registers from the strap |
| strap_cfg | input | 5 | Reset configuration strap |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| par_en | output | 1 | Parallel port enabled |
| par_base | output | ADDR_W | Parallel base address |
| par_irq | output | IRQ_W | Parallel IRQ |
| uart_en | output | NUM_UARTS | Serial port enables |
| uart_base | output | NUM_UARTS x ADDR_W | Serial port base addresses |
| uart_irq | output | NUM_UARTS x IRQ_W | Serial port IRQs |
| fdc_en | output | 1 | Floppy controller enabled |
| fdc_base | output | ADDR_W | Floppy base address |
| fdc_irq | output | IRQ_W | Floppy IRQ |
| ide_en | output | 1 | IDE controller enabled |
| ide_base | output | ADDR_W | IDE primary base |
| ide_alt_base | output | ADDR_W | IDE alternate base |
| ide_irq | output | IRQ_W | IDE IRQ |
| reconf_pulse | output | 1 | One-cycle pulse after an accepted data write |

## Verification
A wrong identifier state shows on the very next index-port read, as an identifier byte where the index was expected or the reverse. A corrupted configuration register shows at once through a data-port readback, and one clock later on the decoded base, IRQ and enable outputs. The strap sweep and the full sweeps of the enable and address registers therefore expose any wrong table entry within a single access. A write that leaks through an invalid index shows as a changed readback or a stray reconfigure pulse two cycles later.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   localparam int CFG_W        = 8;
   localparam int NUM_CFG_REGS = 3;

   // register order is decoded by the index port
   localparam int IDX_ENABLE  = 0;
   localparam int IDX_ADDRESS = 1;
   localparam int IDX_PTEST   = 2;

   // enable register fields
   localparam int EB_PAR     = 0;
   localparam int EB_UART0   = 1;
   localparam int EB_FDC     = 3;
   localparam int EB_FDC_ALT = 5;
   localparam int EB_IDE     = 6;
   localparam int EB_IDE_ALT = 7;

   // power/test field choosing the parallel IRQ for code 0
   localparam int PB_PAR_IRQ7 = 3;

   localparam logic [CFG_W-1:0] CHIP_ID = 8'h88;

   typedef enum logic [1:0] {
      ID_HI   = 2'd0,
      ID_LO   = 2'd1,
      ID_DONE = 2'd2
   } id_state_e;

   function automatic logic [CFG_W-1:0] strap_enable(input logic [4:0] s);
      logic [CFG_W-1:0] v;
      if (s <= 5'd5)       v = 8'h4F;
      else if (s <= 5'd11) v = 8'h4B;
      else if (s <= 5'd15) v = 8'h0F;
      else if (s <= 5'd19) v = 8'h49;
      else if (s <= 5'd23) v = 8'h07;
      else if (s <= 5'd29) v = 8'h47;
      else if (s == 5'd30) v = 8'h08;
      else                 v = 8'h00;
      return v;
   endfunction

   function automatic logic [CFG_W-1:0] strap_address(input logic [4:0] s);
      logic [CFG_W-1:0] v;
      case (s)
         5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26: v = 8'h11;
         5'd3, 5'd14, 5'd22, 5'd27:              v = 8'h39;
         5'd4, 5'd15, 5'd23, 5'd28:              v = 8'h24;
         5'd5, 5'd29:                            v = 8'h38;
         5'd6, 5'd16, 5'd19:                     v = 8'h00;
         5'd7, 5'd8, 5'd17, 5'd18:               v = 8'h01;
         5'd9:                                   v = 8'h09;
         5'd10, 5'd11:                           v = 8'h08;
         default:                                v = 8'h10;
      endcase
      return v;
   endfunction

   function automatic logic [CFG_W-1:0] strap_ptest(input logic [4:0] s);
      return (s == 5'd31) ? 8'h02 : 8'h00;
   endfunction

endpackage

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
   import sio_cfg_pkg::*;
#(
   parameter int NUM_REGS = NUM_CFG_REGS,
   parameter int DATA_W   = CFG_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [4:0]                     strap_i,
   input  logic                           port_sel_i,
   input  logic                           wr_en_i,
   input  logic                           rd_en_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   output logic [DATA_W-1:0]              rd_data_o,
   output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o,
   output logic [DATA_W-1:0]              sel_idx_o,
   output id_state_e                      id_state_o,
   output logic                           accept_q_o
);

   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [DATA_W-1:0]               sel_q;
   id_state_e                       id_q;
   logic                            idx_valid;
   logic                            data_wr;
   logic                            index_wr;
   logic                            index_rd;
   logic [IDX_W-1:0]                idx_lo;

   assign idx_valid = (sel_q < DATA_W'(NUM_REGS));
   assign idx_lo    = sel_q[IDX_W-1:0];
   assign data_wr   = wr_en_i &  port_sel_i & idx_valid;
   assign index_wr  = wr_en_i & ~port_sel_i;
   assign index_rd  = rd_en_i & ~port_sel_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q[IDX_ENABLE]  <= strap_enable(strap_i);
         regs_q[IDX_ADDRESS] <= strap_address(strap_i);
         regs_q[IDX_PTEST]   <= strap_ptest(strap_i);
         sel_q               <= '0;
         id_q                <= ID_HI;
         accept_q_o          <= 1'b0;
      end else begin
         accept_q_o <= data_wr;
         if (index_wr) begin
            sel_q <= wr_data_i;
            id_q  <= ID_DONE;
         end else if (index_rd) begin
            case (id_q)
               ID_HI:   id_q <= ID_LO;
               ID_LO:   id_q <= ID_DONE;
               default: id_q <= ID_DONE;
            endcase
         end
         if (data_wr) begin
            regs_q[idx_lo] <= wr_data_i;
         end
      end
   end

   always_comb begin
      if (port_sel_i) begin
         rd_data_o = idx_valid ? regs_q[idx_lo] : '0;
      end else begin
         case (id_q)
            ID_HI:   rd_data_o = CHIP_ID;
            ID_LO:   rd_data_o = '0;
            default: rd_data_o = sel_q;
         endcase
      end
   end

   assign regs_o     = regs_q;
   assign sel_idx_o  = sel_q;
   assign id_state_o = id_q;

endmodule

// File: rtl/sio_uart_map.sv
module sio_uart_map #(
   parameter int ADDR_W = 16,
   parameter int IRQ_W  = 4
) (
   input  logic [1:0]        code_i,
   input  logic [1:0]        alias_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [IRQ_W-1:0]  irq_o
);

   always_comb begin
      case (code_i)
         2'd0: base_o = ADDR_W'(16'h3F8);
         2'd1: base_o = ADDR_W'(16'h2F8);
         2'd2: begin
            case (alias_i)
               2'd0:    base_o = ADDR_W'(16'h3E8);
               2'd1:    base_o = ADDR_W'(16'h338);
               2'd2:    base_o = ADDR_W'(16'h2E8);
               default: base_o = ADDR_W'(16'h220);
            endcase
         end
         default: begin
            case (alias_i)
               2'd0:    base_o = ADDR_W'(16'h2E8);
               2'd1:    base_o = ADDR_W'(16'h238);
               2'd2:    base_o = ADDR_W'(16'h2E0);
               default: base_o = ADDR_W'(16'h228);
            endcase
         end
      endcase
      irq_o = code_i[0] ? IRQ_W'(3) : IRQ_W'(4);
   end

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int IRQ_W     = 4,
   parameter int NUM_UARTS = 2,
   parameter int FDC_IRQ   = 6,
   parameter int IDE_IRQ   = 14,
   parameter int IDE_ALT   = 'h206
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [CFG_W-1:0]                      en_reg_i,
   input  logic [CFG_W-1:0]                      addr_reg_i,
   input  logic                                  par_irq7_i,
   input  logic                                  accept_q_i,
   output logic                                  par_en_o,
   output logic [ADDR_W-1:0]                     par_base_o,
   output logic [IRQ_W-1:0]                      par_irq_o,
   output logic [NUM_UARTS-1:0]                  uart_en_o,
   output logic [NUM_UARTS-1:0][ADDR_W-1:0]      uart_base_o,
   output logic [NUM_UARTS-1:0][IRQ_W-1:0]       uart_irq_o,
   output logic                                  fdc_en_o,
   output logic [ADDR_W-1:0]                     fdc_base_o,
   output logic [IRQ_W-1:0]                      fdc_irq_o,
   output logic                                  ide_en_o,
   output logic [ADDR_W-1:0]                     ide_base_o,
   output logic [ADDR_W-1:0]                     ide_alt_base_o,
   output logic [IRQ_W-1:0]                      ide_irq_o,
   output logic                                  reconf_o
);

   logic [ADDR_W-1:0] par_base_c;
   logic [IRQ_W-1:0]  par_irq_c;
   logic [ADDR_W-1:0] ide_base_c;

   always_comb begin
      case (addr_reg_i[1:0])
         2'd0: begin
            par_base_c = ADDR_W'(16'h378);
            par_irq_c  = par_irq7_i ? IRQ_W'(7) : IRQ_W'(5);
         end
         2'd1: begin
            par_base_c = ADDR_W'(16'h3BC);
            par_irq_c  = IRQ_W'(7);
         end
         2'd2: begin
            par_base_c = ADDR_W'(16'h278);
            par_irq_c  = IRQ_W'(5);
         end
         default: begin
            par_base_c = '0;
            par_irq_c  = '0;
         end
      endcase
      ide_base_c = en_reg_i[EB_IDE_ALT] ? ADDR_W'(16'h170) : ADDR_W'(16'h1F0);
   end

   for (genvar u = 0; u < NUM_UARTS; u++) begin : g_uart
      logic [ADDR_W-1:0] base_c;
      logic [IRQ_W-1:0]  irq_c;

      sio_uart_map #(
         .ADDR_W (ADDR_W),
         .IRQ_W  (IRQ_W)
      ) u_map (
         .code_i  (addr_reg_i[2*u+3 -: 2]),
         .alias_i (addr_reg_i[7:6]),
         .base_o  (base_c),
         .irq_o   (irq_c)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            uart_en_o[u]   <= 1'b0;
            uart_base_o[u] <= '0;
            uart_irq_o[u]  <= '0;
         end else begin
            uart_en_o[u]   <= en_reg_i[EB_UART0+u];
            uart_base_o[u] <= base_c;
            uart_irq_o[u]  <= irq_c;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_en_o       <= 1'b0;
         par_base_o     <= '0;
         par_irq_o      <= '0;
         fdc_en_o       <= 1'b0;
         fdc_base_o     <= '0;
         fdc_irq_o      <= '0;
         ide_en_o       <= 1'b0;
         ide_base_o     <= '0;
         ide_alt_base_o <= '0;
         ide_irq_o      <= '0;
         reconf_o       <= 1'b0;
      end else begin
         par_en_o       <= en_reg_i[EB_PAR];
         par_base_o     <= par_base_c;
         par_irq_o      <= par_irq_c;
         fdc_en_o       <= en_reg_i[EB_FDC];
         fdc_base_o     <= en_reg_i[EB_FDC_ALT] ? ADDR_W'(16'h370) : ADDR_W'(16'h3F0);
         fdc_irq_o      <= IRQ_W'(FDC_IRQ);
         ide_en_o       <= en_reg_i[EB_IDE];
         ide_base_o     <= ide_base_c;
         ide_alt_base_o <= ide_base_c + ADDR_W'(IDE_ALT);
         ide_irq_o      <= IRQ_W'(IDE_IRQ);
         reconf_o       <= accept_q_i;
      end
   end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int IRQ_W     = 4,
   parameter int NUM_UARTS = 2,
   parameter int FDC_IRQ   = 6,
   parameter int IDE_IRQ   = 14
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [4:0]                       strap_cfg,
   input  logic                             port_sel,
   input  logic                             wr_en,
   input  logic                             rd_en,
   input  logic [7:0]                       wr_data,
   output logic [7:0]                       rd_data,
   output logic                             par_en,
   output logic [ADDR_W-1:0]                par_base,
   output logic [IRQ_W-1:0]                 par_irq,
   output logic [NUM_UARTS-1:0]             uart_en,
   output logic [NUM_UARTS-1:0][ADDR_W-1:0] uart_base,
   output logic [NUM_UARTS-1:0][IRQ_W-1:0]  uart_irq,
   output logic                             fdc_en,
   output logic [ADDR_W-1:0]                fdc_base,
   output logic [IRQ_W-1:0]                 fdc_irq,
   output logic                             ide_en,
   output logic [ADDR_W-1:0]                ide_base,
   output logic [ADDR_W-1:0]                ide_alt_base,
   output logic [IRQ_W-1:0]                 ide_irq,
   output logic                             reconf_pulse
);

   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("ADDR_W must hold a 12-bit I/O address");
   end
   if (IRQ_W < 4) begin : g_bad_irq_w
      $error("IRQ_W must hold IRQ numbers up to 15");
   end
   if (NUM_UARTS < 1 || NUM_UARTS > 2) begin : g_bad_uarts
      $error("NUM_UARTS must be 1 or 2");
   end
   if (FDC_IRQ >= (1 << IRQ_W) || IDE_IRQ >= (1 << IRQ_W)) begin : g_bad_irq
      $error("fixed IRQ numbers exceed IRQ_W");
   end

   logic [NUM_CFG_REGS-1:0][CFG_W-1:0] regs;
   logic [CFG_W-1:0]                   sel_idx;
   id_state_e                          id_state;
   logic                               accept_q;
   logic [CFG_W-1:0]                   reg_en;
   logic [CFG_W-1:0]                   reg_addr;
   logic [CFG_W-1:0]                   reg_pt;

   sio_cfg_regfile #(
      .NUM_REGS (NUM_CFG_REGS),
      .DATA_W   (CFG_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_i    (strap_cfg),
      .port_sel_i (port_sel),
      .wr_en_i    (wr_en),
      .rd_en_i    (rd_en),
      .wr_data_i  (wr_data),
      .rd_data_o  (rd_data),
      .regs_o     (regs),
      .sel_idx_o  (sel_idx),
      .id_state_o (id_state),
      .accept_q_o (accept_q)
   );

   assign reg_en   = regs[IDX_ENABLE];
   assign reg_addr = regs[IDX_ADDRESS];
   assign reg_pt   = regs[IDX_PTEST];

   sio_cfg_decode #(
      .ADDR_W    (ADDR_W),
      .IRQ_W     (IRQ_W),
      .NUM_UARTS (NUM_UARTS),
      .FDC_IRQ   (FDC_IRQ),
      .IDE_IRQ   (IDE_IRQ)
   ) u_dec (
      .clk            (clk),
      .rst_n          (rst_n),
      .en_reg_i       (reg_en),
      .addr_reg_i     (reg_addr),
      .par_irq7_i     (reg_pt[PB_PAR_IRQ7]),
      .accept_q_i     (accept_q),
      .par_en_o       (par_en),
      .par_base_o     (par_base),
      .par_irq_o      (par_irq),
      .uart_en_o      (uart_en),
      .uart_base_o    (uart_base),
      .uart_irq_o     (uart_irq),
      .fdc_en_o       (fdc_en),
      .fdc_base_o     (fdc_base),
      .fdc_irq_o      (fdc_irq),
      .ide_en_o       (ide_en),
      .ide_base_o     (ide_base),
      .ide_alt_base_o (ide_alt_base),
      .ide_irq_o      (ide_irq),
      .reconf_o       (reconf_pulse)
   );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int IRQ_W     = 4,
   parameter int NUM_UARTS = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            port_sel,
   input logic                            wr_en,
   input logic                            rd_en,
   input logic [7:0]                      wr_data,
   input logic [7:0]                      rd_data,
   input logic [7:0]                      sel_idx,
   input logic [1:0]                      id_state,
   input logic [7:0]                      reg_en,
   input logic [7:0]                      reg_addr,
   input logic [7:0]                      reg_pt,
   input logic                            par_en,
   input logic [ADDR_W-1:0]               fdc_base,
   input logic [NUM_UARTS-1:0][IRQ_W-1:0] uart_irq,
   input logic                            reconf_pulse
);

   logic armed;
   logic good_wr;
   logic bad_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign good_wr = wr_en && port_sel && (sel_idx < 8'd3);
   assign bad_wr  = wr_en && port_sel && (sel_idx >= 8'd3);

   a_r1_first_read_id: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !port_sel && id_state == ID_HI) |-> rd_data == CHIP_ID);

   a_r1_second_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !port_sel && id_state == ID_LO) |-> rd_data == 8'h00);

   a_r2_index_write_ends_id: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !port_sel) |=> (id_state == ID_DONE && sel_idx == $past(wr_data)));

   a_r4_bad_index_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && port_sel && sel_idx >= 8'd3) |-> rd_data == 8'h00);

   a_r4_bad_index_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> ($stable(reg_en) && $stable(reg_addr) && $stable(reg_pt)));

   a_r6_par_en_follows: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      par_en == $past(reg_en[0]));

   a_r7_fdc_base_follows: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      fdc_base == ($past(reg_en[5]) ? ADDR_W'(16'h370) : ADDR_W'(16'h3F0)));

   a_r11_uart_irq_parity: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      uart_irq[0] == ($past(reg_addr[2]) ? IRQ_W'(3) : IRQ_W'(4)));

   a_r12_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      reconf_pulse |-> $past(good_wr, 2));

   a_r12_write_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |-> ##2 reconf_pulse);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .ADDR_W    (ADDR_W),
   .IRQ_W     (IRQ_W),
   .NUM_UARTS (NUM_UARTS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .port_sel     (port_sel),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .wr_data      (wr_data),
   .rd_data      (rd_data),
   .sel_idx      (sel_idx),
   .id_state     (id_state),
   .reg_en       (reg_en),
   .reg_addr     (reg_addr),
   .reg_pt       (reg_pt),
   .par_en       (par_en),
   .fdc_base     (fdc_base),
   .uart_irq     (uart_irq),
   .reconf_pulse (reconf_pulse)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

   localparam int AW = 16;
   localparam int IW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        strap_cfg = 5'd0;
   logic              port_sel = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [7:0]        wr_data = 8'h00;
   logic [7:0]        rd_data;
   logic              par_en;
   logic [AW-1:0]     par_base;
   logic [IW-1:0]     par_irq;
   logic [1:0]        uart_en;
   logic [1:0][AW-1:0] uart_base;
   logic [1:0][IW-1:0] uart_irq;
   logic              fdc_en;
   logic [AW-1:0]     fdc_base;
   logic [IW-1:0]     fdc_irq;
   logic              ide_en;
   logic [AW-1:0]     ide_base;
   logic [AW-1:0]     ide_alt_base;
   logic [IW-1:0]     ide_irq;
   logic              reconf_pulse;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   sio_cfg_port u_sio_cfg_port (
      .clk(clk), .rst_n(rst_n), .strap_cfg(strap_cfg), .port_sel(port_sel),
      .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
      .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
      .uart_en(uart_en), .uart_base(uart_base), .uart_irq(uart_irq),
      .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
      .ide_en(ide_en), .ide_base(ide_base), .ide_alt_base(ide_alt_base),
      .ide_irq(ide_irq), .reconf_pulse(reconf_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic do_wr(input logic a, input logic [7:0] d);
      port_sel = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic a, output logic [7:0] d);
      port_sel = a; rd_en = 1'b1;
      #2 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic do_reset(input logic [4:0] s);
      rst_n = 1'b0; strap_cfg = s;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [7:0] ref_en(input int s);
      case (s)
         0, 1, 2, 3, 4, 5:         return 8'h4F;
         6, 7, 8, 9, 10, 11:       return 8'h4B;
         12, 13, 14, 15:           return 8'h0F;
         16, 17, 18, 19:           return 8'h49;
         20, 21, 22, 23:           return 8'h07;
         24, 25, 26, 27, 28, 29:   return 8'h47;
         30:                       return 8'h08;
         default:                  return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] ref_addr(input int s);
      logic [7:0] grp [0:5];
      grp[0] = 8'h10; grp[1] = 8'h11; grp[2] = 8'h11;
      grp[3] = 8'h39; grp[4] = 8'h24; grp[5] = 8'h38;
      if (s <= 5)  return grp[s];
      if (s >= 24 && s <= 29) return grp[s-24];
      if (s >= 12 && s <= 15) return grp[s-12 + (s == 12 ? 0 : (s == 13 ? 0 : 1))];
      if (s >= 20 && s <= 23) return grp[s-20 + (s >= 22 ? 1 : 0)];
      case (s)
         6, 16, 19: return 8'h00;
         7, 8, 17, 18: return 8'h01;
         9: return 8'h09;
         10, 11: return 8'h08;
         default: return 8'h10;
      endcase
   endfunction

   function automatic logic [15:0] ref_uart(input int code, input int al);
      if (code == 0) return 16'h3F8;
      if (code == 1) return 16'h2F8;
      if (code == 2) begin
         case (al) 0: return 16'h3E8; 1: return 16'h338; 2: return 16'h2E8; default: return 16'h220; endcase
      end
      case (al) 0: return 16'h2E8; 1: return 16'h238; 2: return 16'h2E0; default: return 16'h228; endcase
   endfunction

   initial begin
      logic [7:0] d;
      int ch;
      @(negedge clk);
      @(negedge clk);
      do_reset(5'd0);

      // reset state at the ports, strap 0 (enable 0x4F, address 0x10)
      chk("R5 reset pulse low", reconf_pulse, 0);
      chk("R6 reset par_en", par_en, 1);
      chk("R6 reset ide_en", ide_en, 1);
      chk("R10 reset uart0 base", uart_base[0], 16'h3F8);

      // strap sweep with identifier sequence
      for (int s = 0; s < 32; s++) begin
         do_reset(5'(s));
         do_rd(1'b0, d); chk("R1 first id read", d, 8'h88);
         do_rd(1'b0, d); chk("R1 second id read", d, 8'h00);
         do_rd(1'b0, d); chk("R5 index resets to 0", d, 8'h00);
         do_rd(1'b1, d); chk("R5 strap enable", d, ref_en(s));
         do_wr(1'b0, 8'd1);
         do_rd(1'b1, d); chk("R5 strap address", d, ref_addr(s));
         do_wr(1'b0, 8'd2);
         do_rd(1'b1, d); chk("R5 strap power/test", d, (s == 31) ? 8'h02 : 8'h00);
      end

      // index write before any read ends the sequence
      do_reset(5'd13);
      do_wr(1'b0, 8'd2);
      do_rd(1'b0, d); chk("R2 index readback", d, 8'd2);
      do_wr(1'b0, 8'hC5);
      do_rd(1'b0, d); chk("R2 index readback any byte", d, 8'hC5);

      // data write, readback, one-cycle latency and pulse
      do_wr(1'b0, 8'd0);
      do_wr(1'b1, 8'h20);
      chk("R12 outputs not yet updated", fdc_base, 16'h3F0);
      chk("R12 pulse not yet", reconf_pulse, 0);
      @(negedge clk);
      chk("R12 fdc base after one cycle", fdc_base, 16'h370);
      chk("R12 pulse high", reconf_pulse, 1);
      @(negedge clk);
      chk("R12 pulse one cycle only", reconf_pulse, 0);
      do_rd(1'b1, d); chk("R3 enable readback", d, 8'h20);

      // invalid indices: writes ignored, reads zero
      for (int k = 0; k < 3; k++) begin
         logic [7:0] bi;
         bi = (k == 0) ? 8'd3 : ((k == 1) ? 8'h7F : 8'hFF);
         do_wr(1'b0, bi);
         do_wr(1'b1, 8'hAA);
         do_rd(1'b1, d); chk("R4 invalid index read", d, 8'h00);
         @(negedge clk);
         chk("R4 no pulse on invalid write", reconf_pulse, 0);
         chk("R4 fdc base unchanged", fdc_base, 16'h370);
      end
      do_wr(1'b0, 8'd0); do_rd(1'b1, d); chk("R4 enable unchanged", d, 8'h20);
      do_wr(1'b0, 8'd1); do_rd(1'b1, d); chk("R4 address unchanged", d, 8'h11);
      do_wr(1'b0, 8'd2); do_rd(1'b1, d); chk("R4 power/test unchanged", d, 8'h00);

      // enable register sweep
      do_wr(1'b0, 8'd0);
      for (int v = 0; v < 256; v++) begin
         do_wr(1'b1, 8'(v));
         @(negedge clk);
         chk("R6 par_en", par_en, (v >> 0) & 1);
         chk("R6 uart_en", uart_en, (v >> 1) & 3);
         chk("R6 fdc_en", fdc_en, (v >> 3) & 1);
         chk("R6 ide_en", ide_en, (v >> 6) & 1);
         chk("R7 fdc base", fdc_base, ((v >> 5) & 1) ? 16'h370 : 16'h3F0);
         chk("R7 fdc irq", fdc_irq, 6);
         chk("R8 ide base", ide_base, ((v >> 7) & 1) ? 16'h170 : 16'h1F0);
         chk("R8 ide alt base", ide_alt_base, (((v >> 7) & 1) ? 32'h170 : 32'h1F0) + 32'h206);
         chk("R8 ide irq", ide_irq, 14);
      end
      do_rd(1'b1, d); chk("R3 last enable readback", d, 8'hFF);

      // address register sweep, both settings of power/test bit 3
      for (int p = 0; p < 2; p++) begin
         do_wr(1'b0, 8'd2);
         do_wr(1'b1, p ? 8'h08 : 8'h00);
         do_wr(1'b0, 8'd1);
         for (int v = 0; v < 256; v++) begin
            int pc;
            do_wr(1'b1, 8'(v));
            @(negedge clk);
            pc = v & 3;
            chk("R9 parallel base", par_base,
                (pc == 0) ? 16'h378 : (pc == 1) ? 16'h3BC : (pc == 2) ? 16'h278 : 16'h0);
            chk("R9 parallel irq", par_irq,
                (pc == 0) ? (p ? 7 : 5) : (pc == 1) ? 7 : (pc == 2) ? 5 : 0);
            for (int u = 0; u < 2; u++) begin
               ch = (v >> (2*u + 2)) & 3;
               chk("R10 uart base", uart_base[u], ref_uart(ch, (v >> 6) & 3));
               chk("R11 uart irq", uart_irq[u], (ch % 2 == 1) ? 3 : 4);
            end
         end
      end
      do_rd(1'b1, d); chk("R3 last address readback", d, 8'hFF);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule